// File: doc/BRIEF.md
# ECC QWord Write/Read Datapath

This block sits between the host side of a memory controller and a synchronous array of 64-bit words. Every stored word carries eight check bits. These are a Hamming code extended by an overall parity bit, which gives single-error correction and double-error detection. On a read, the block recomputes the check bits and decodes the syndrome. The 2-bit integrity mode then decides what happens: the result may be ignored, reported only, corrected, or corrected and written back to the array.

A write that enables only some bytes of a word cannot update the check bits by itself. With checking on, such a write is therefore done as a read-modify-write. The block reads the old word, repairs it if it can, merges in the enabled bytes and writes the whole word back with new check bits. If the old word cannot be trusted, the merge is dropped.

Each error that is seen is reported to an external logger as a single-cycle event. The event carries the error type and the word address.

Top module: `ecc_qword_path`

## Requirements
- R1: A write with all byte enables set stores the data together with freshly generated check bits, in any mode. A later read in modes 01, 10 or 11 returns the same data with no event.
- R2: The mode field is `integ_mode` (00 off, 01 detect, 10 correct, 11 correct plus scrub). In mode 00 a read returns the stored data bits unchanged and raises no event. A partial write in mode 00 updates only the enabled data bytes and leaves the stored check bits unchanged.
- R3: In mode 01 a read reports a single-bit error (`evt_multi`=0) or a multi-bit error (`evt_multi`=1) and returns the stored data uncorrected.
- R4: In modes 10 and 11 a read of a word with one flipped data bit returns the corrected data and raises a single-bit event.
- R5: In modes 10 and 11 a read of a word with two flipped bits returns the stored data unchanged and raises a multi-bit event. No writeback follows.
- R6: In mode 11 a read with a single-bit error writes the corrected word back to the array, so a later read raises no event. In mode 10 nothing is written back.
- R7: `req_ready` is high only when the block is idle. `rsp_valid` is high for exactly the one cycle after the cycle in which a read is accepted. A scrub writeback takes the following cycle, with `req_ready` low, before any new request is taken.
- R8: A partial write in modes 01 to 11 replaces byte b of the stored word with `req_wdata[8b+7:8b]` wherever `req_be[b]` is 1. All other bytes keep their stored values, and the check bits are regenerated.
- R9: During a read-modify-write the array is left unchanged and an event is raised if the old word has a multi-bit error, or if it has any error in mode 01.
- R10: During a read-modify-write in modes 10 and 11, a single-bit error in the old word is corrected before the merge, and a single-bit event is raised.
- R11: An event is high for one cycle only. It carries the address of the word that was accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| integ_mode | input | 2 | Integrity mode, sampled when a request is accepted |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte enables for writes |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DATA_W | Read data, corrected in modes 10 and 11 |
| evt_valid | output | 1 | Error event pulse |
| evt_multi | output | 1 | 1 = multi-bit error, 0 = single-bit error |
| evt_addr | output | ADDR_W | Address of the failing word |

## Verification
Errors are injected through the normal port interface. A full-word write puts a clean word in the array, and a partial write in mode 00 then flips data bits while the old check bits stay in place.

Faults inside the block show up at the ports in three ways:
- A bad check-bit table or syndrome table appears on the next read of that word, as wrong returned data or a missing or wrongly typed event.
- A missing or extra scrub writeback is not visible on the read that triggers it. It shows one read later, as an event that should or should not repeat, and as `req_ready` staying high or dropping in the cycle after the response.
- A wrong merge or a wrong abort decision in the read-modify-write path is seen on the next read of that address.

// File: rtl/ecc_qw_pkg.sv
package ecc_qw_pkg;

   typedef enum logic [1:0] {
      INTEG_OFF     = 2'b00,
      INTEG_DETECT  = 2'b01,
      INTEG_CORRECT = 2'b10,
      INTEG_SCRUB   = 2'b11
   } integ_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RD    = 2'd1,
      ST_RMW   = 2'd2,
      ST_SCRUB = 2'd3
   } path_state_e;

   // number of Hamming position bits needed to cover dw data bits
   function automatic int hamming_bits(input int dw);
      int r;
      r = 1;
      while ((1 << r) < dw + r + 1) r++;
      return r;
   endfunction

   // code position (1-based, never a power of two) of data bit idx
   function automatic int data_slot(input int idx);
      int cnt;
      int res;
      cnt = 0;
      res = 0;
      for (int p = 3; p < 2 * idx + 16; p++) begin
         if ((p & (p - 1)) != 0) begin
            if (cnt == idx && res == 0) res = p;
            cnt++;
         end
      end
      return res;
   endfunction

endpackage

// File: rtl/ecc_qw_enc.sv
module ecc_qw_enc #(
   parameter int DATA_W = 64,
   parameter int CHK_W  = ecc_qw_pkg::hamming_bits(DATA_W) + 1
) (
   input  logic [DATA_W-1:0] data,
   output logic [CHK_W-1:0]  chk
);
   localparam int HB = CHK_W - 1;

   if (CHK_W != ecc_qw_pkg::hamming_bits(DATA_W) + 1) begin : g_bad_chk
      $fatal(1, "ecc_qw_enc: CHK_W does not match DATA_W");
   end

   logic [HB-1:0] slot [DATA_W];

   for (genvar i = 0; i < DATA_W; i++) begin : g_slot
      localparam int SLOT = ecc_qw_pkg::data_slot(i);
      assign slot[i] = HB'(SLOT);
   end

   logic [HB-1:0] hp;

   // XOR of the positions of all set data bits gives the Hamming bits
   always_comb begin
      hp = '0;
      for (int i = 0; i < DATA_W; i++) begin
         if (data[i]) hp = hp ^ slot[i];
      end
   end

   assign chk = {(^data) ^ (^hp), hp};

endmodule

// File: rtl/ecc_qw_dec.sv
module ecc_qw_dec #(
   parameter int DATA_W = 64,
   parameter int CHK_W  = ecc_qw_pkg::hamming_bits(DATA_W) + 1
) (
   input  logic [DATA_W-1:0] data,
   input  logic [CHK_W-1:0]  chk,
   output logic [DATA_W-1:0] corr_data,
   output logic              err_single,
   output logic              err_multi
);
   localparam int HB = CHK_W - 1;

   logic [CHK_W-1:0]  regen;
   logic [HB-1:0]     syn;
   logic              par_bad;
   logic [DATA_W-1:0] flip;

   ecc_qw_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_regen (
      .data (data),
      .chk  (regen)
   );

   assign syn     = regen[HB-1:0] ^ chk[HB-1:0];
   // equals the parity of all stored data and check bits
   assign par_bad = regen[HB] ^ chk[HB] ^ (^syn);

   assign err_single = par_bad;
   assign err_multi  = !par_bad && (syn != '0);

   for (genvar i = 0; i < DATA_W; i++) begin : g_fix
      localparam int SLOT = ecc_qw_pkg::data_slot(i);
      assign flip[i] = par_bad && (syn == HB'(SLOT));
   end

   assign corr_data = data ^ flip;

endmodule

// File: rtl/ecc_qw_ram.sv
module ecc_qw_ram #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 64,
   parameter int CHK_W  = 8,
   localparam int NB    = DATA_W / 8,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              we,
   input  logic [NB-1:0]     be,
   input  logic              chk_we,
   input  logic              re,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [CHK_W-1:0]  wchk,
   output logic [DATA_W-1:0] rdata,
   output logic [CHK_W-1:0]  rchk
);
   logic [DATA_W-1:0] dmem [DEPTH];
   logic [CHK_W-1:0]  cmem [DEPTH];

   always_ff @(posedge clk) begin
      for (int b = 0; b < NB; b++) begin
         if (we && be[b]) dmem[addr][b*8 +: 8] <= wdata[b*8 +: 8];
      end
      if (we && chk_we) cmem[addr] <= wchk;
      if (re) begin
         rdata <= dmem[addr];
         rchk  <= cmem[addr];
      end
   end

endmodule

// File: rtl/ecc_qword_path.sv
module ecc_qword_path #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 64,
   parameter int CHK_W  = ecc_qw_pkg::hamming_bits(DATA_W) + 1,
   localparam int NB    = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        integ_mode,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [NB-1:0]     req_be,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              evt_valid,
   output logic              evt_multi,
   output logic [ADDR_W-1:0] evt_addr
);
   import ecc_qw_pkg::*;

   if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_width
      $fatal(1, "ecc_qword_path: DATA_W must be a multiple of 8");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $fatal(1, "ecc_qword_path: ADDR_W must be at least 1");
   end

   path_state_e       state_q, state_d;
   integ_mode_e       mode_q, mode_in;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q, scrub_q;
   logic [NB-1:0]     be_q;

   logic              accept, full_be;
   logic              ram_we, ram_chk_we, ram_re;
   logic [NB-1:0]     ram_be;
   logic [ADDR_W-1:0] ram_addr;
   logic [DATA_W-1:0] wr_data, ram_rdata, corr, base, merged;
   logic [CHK_W-1:0]  wr_chk, ram_rchk;
   logic              dec_single, dec_multi, chk_on, fix_on, err_seen, rmw_abort;

   assign mode_in = integ_mode_e'(integ_mode);
   assign accept  = req_valid && req_ready;
   assign full_be = &req_be;

   ecc_qw_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHK_W(CHK_W)) u_ram (
      .clk    (clk),
      .we     (ram_we),
      .be     (ram_be),
      .chk_we (ram_chk_we),
      .re     (ram_re),
      .addr   (ram_addr),
      .wdata  (wr_data),
      .wchk   (wr_chk),
      .rdata  (ram_rdata),
      .rchk   (ram_rchk)
   );

   ecc_qw_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc (
      .data (wr_data),
      .chk  (wr_chk)
   );

   ecc_qw_dec #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_dec (
      .data       (ram_rdata),
      .chk        (ram_rchk),
      .corr_data  (corr),
      .err_single (dec_single),
      .err_multi  (dec_multi)
   );

   assign chk_on    = (mode_q != INTEG_OFF);
   assign fix_on    = mode_q[1];
   assign err_seen  = chk_on && (dec_single || dec_multi);
   assign rmw_abort = dec_multi || (dec_single && !fix_on);
   assign base      = fix_on ? corr : ram_rdata;

   for (genvar b = 0; b < NB; b++) begin : g_merge
      assign merged[b*8 +: 8] = be_q[b] ? wdata_q[b*8 +: 8] : base[b*8 +: 8];
   end

   assign req_ready = (state_q == ST_IDLE);
   assign rsp_rdata = fix_on ? corr : ram_rdata;
   assign evt_multi = dec_multi;
   assign evt_addr  = addr_q;

   always_comb begin
      state_d    = state_q;
      ram_we     = 1'b0;
      ram_be     = '0;
      ram_chk_we = 1'b0;
      ram_re     = 1'b0;
      ram_addr   = addr_q;
      wr_data    = req_wdata;
      rsp_valid  = 1'b0;
      evt_valid  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            ram_addr = req_addr;
            if (accept) begin
               if (!req_write) begin
                  ram_re  = 1'b1;
                  state_d = ST_RD;
               end else if (full_be || mode_in == INTEG_OFF) begin
                  ram_we     = 1'b1;
                  ram_be     = req_be;
                  ram_chk_we = full_be;
               end else begin
                  ram_re  = 1'b1;
                  state_d = ST_RMW;
               end
            end
         end
         ST_RD: begin
            rsp_valid = 1'b1;
            evt_valid = err_seen;
            state_d   = (mode_q == INTEG_SCRUB && dec_single) ? ST_SCRUB : ST_IDLE;
         end
         ST_RMW: begin
            evt_valid = err_seen;
            wr_data   = merged;
            if (!rmw_abort) begin
               ram_we     = 1'b1;
               ram_be     = '1;
               ram_chk_we = 1'b1;
            end
            state_d = ST_IDLE;
         end
         ST_SCRUB: begin
            wr_data    = scrub_q;
            ram_we     = 1'b1;
            ram_be     = '1;
            ram_chk_we = 1'b1;
            state_d    = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         mode_q  <= INTEG_OFF;
         addr_q  <= '0;
         wdata_q <= '0;
         be_q    <= '0;
         scrub_q <= '0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            mode_q  <= mode_in;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_be;
         end
         if (state_q == ST_RD) scrub_q <= corr;
      end
   end

   // R7
   rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !req_write) |=> rsp_valid);

   // R11
   evt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |=> !evt_valid);

   // R2
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == INTEG_OFF) |-> !evt_valid);

   // R6
   scrub_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && evt_valid && !evt_multi && mode_q == INTEG_SCRUB)
      |=> (ram_we && ram_chk_we && !req_ready));

   // R9
   rmw_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RMW && evt_valid && evt_multi) |-> !ram_we);

endmodule

// File: tb/ecc_qword_path_tb.sv
module ecc_qword_path_tb;

   localparam int AW = 6;
   localparam int DW = 64;
   localparam int NB = DW / 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    integ_mode = 2'b10;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [NB-1:0] req_be = '0;
   logic          rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic          evt_valid;
   logic          evt_multi;
   logic [AW-1:0] evt_addr;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   logic [DW-1:0] exp_rsp_d[$];
   string         exp_rsp_tag[$];
   logic [AW:0]   exp_evt_d[$];
   string         exp_evt_tag[$];

   always #2 clk = ~clk;

   ecc_qword_path #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .integ_mode (integ_mode),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_write  (req_write),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .req_be     (req_be),
      .rsp_valid  (rsp_valid),
      .rsp_rdata  (rsp_rdata),
      .evt_valid  (evt_valid),
      .evt_multi  (evt_multi),
      .evt_addr   (evt_addr)
   );

   task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [NB-1:0] be);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = a;
      req_wdata = d;
      req_be    = be;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic set_mode(input logic [1:0] m);
      while (!req_ready) @(negedge clk);
      integ_mode = m;
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
      exp_rsp_d.push_back(exp);
      exp_rsp_tag.push_back(tag);
      drive(1'b0, a, '0, '0);
   endtask

   task automatic want_evt(input bit multi, input logic [AW-1:0] a, input string tag);
      exp_evt_d.push_back({multi, a});
      exp_evt_tag.push_back(tag);
   endtask

   // monitor: pops the scoreboard as the design produces results
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (rsp_valid) begin
               if (exp_rsp_d.size() == 0)
                  check(1'b0, "R7 unexpected response", rsp_rdata, '0);
               else begin
                  logic [DW-1:0] e;
                  string t;
                  e = exp_rsp_d.pop_front();
                  t = exp_rsp_tag.pop_front();
                  check(rsp_rdata === e, t, rsp_rdata, e);
               end
            end
            if (evt_valid) begin
               if (exp_evt_d.size() == 0)
                  check(1'b0, "R11 unexpected event", {57'd0, evt_multi, evt_addr}, '0);
               else begin
                  logic [AW:0] e;
                  string t;
                  e = exp_evt_d.pop_front();
                  t = exp_evt_tag.pop_front();
                  check({evt_multi, evt_addr} === e, t,
                        {57'd0, evt_multi, evt_addr}, {57'd0, e});
               end
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] d0, d1, d2, d3, d4, w;
      d0 = 64'h0123_4567_89AB_CDEF;
      d1 = 64'hFFFF_0000_A5A5_5A5A;
      d2 = 64'h1111_2222_3333_4444;
      d3 = 64'hDEAD_BEEF_CAFE_F00D;
      d4 = 64'h7777_8888_9999_AAAA;
      w  = 64'hBBBB_CCCC_DDDD_EEEE;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state (R7, R11)
      check(req_ready === 1'b1, "R7 ready after reset", {63'd0, req_ready}, 64'd1);
      check(rsp_valid === 1'b0, "R7 no response after reset", {63'd0, rsp_valid}, 64'd0);
      check(evt_valid === 1'b0, "R11 no event after reset", {63'd0, evt_valid}, 64'd0);

      // R1 clean write/read, including top address
      set_mode(2'b10);
      drive(1'b1, 6'd0, d0, 8'hFF);
      drive(1'b1, 6'd63, d1, 8'hFF);
      rd(6'd0, d0, "R1 clean read addr 0");
      rd(6'd63, d1, "R1 clean read addr 63");
      set_mode(2'b01);
      rd(6'd0, d0, "R1 clean read detect mode");

      // R2 inject single-bit error through an off-mode partial write
      set_mode(2'b00);
      drive(1'b1, 6'd0, {56'd0, d0[7:0] ^ 8'h01}, 8'h01);
      rd(6'd0, d0 ^ 64'h1, "R2 off mode raw read");

      // R3 detect-only single
      set_mode(2'b01);
      want_evt(1'b0, 6'd0, "R3 single event detect");
      rd(6'd0, d0 ^ 64'h1, "R3 detect returns raw");

      // R4 correct mode, no scrub
      set_mode(2'b10);
      want_evt(1'b0, 6'd0, "R4 single event correct");
      rd(6'd0, d0, "R4 corrected data");
      @(negedge clk);
      check(req_ready === 1'b1, "R6 no writeback in mode 10", {63'd0, req_ready}, 64'd1);
      want_evt(1'b0, 6'd0, "R6 error persists in mode 10");
      rd(6'd0, d0, "R6 corrected data again");

      // R6/R7 scrub mode
      set_mode(2'b11);
      want_evt(1'b0, 6'd0, "R6 single event scrub");
      rd(6'd0, d0, "R6 scrub corrected data");
      @(negedge clk);
      check(req_ready === 1'b0, "R7 ready low during scrub", {63'd0, req_ready}, 64'd0);
      @(negedge clk);
      check(req_ready === 1'b1, "R7 ready back after scrub", {63'd0, req_ready}, 64'd1);
      rd(6'd0, d0, "R6 scrubbed word clean");

      // double-bit error: R3 and R5
      set_mode(2'b00);
      drive(1'b1, 6'd0, {56'd0, d0[7:0] ^ 8'h03}, 8'h01);
      set_mode(2'b01);
      want_evt(1'b1, 6'd0, "R3 multi event detect");
      rd(6'd0, d0 ^ 64'h3, "R3 multi raw data");
      set_mode(2'b10);
      want_evt(1'b1, 6'd0, "R5 multi event correct");
      rd(6'd0, d0 ^ 64'h3, "R5 multi raw data");
      set_mode(2'b11);
      want_evt(1'b1, 6'd0, "R5 multi event scrub mode");
      rd(6'd0, d0 ^ 64'h3, "R5 multi raw data scrub mode");
      @(negedge clk);
      check(req_ready === 1'b1, "R5 no writeback on multi", {63'd0, req_ready}, 64'd1);

      // R8 clean read-modify-write
      set_mode(2'b10);
      drive(1'b1, 6'd1, d2, 8'hFF);
      drive(1'b1, 6'd1, w, 8'hF0);
      rd(6'd1, {w[63:32], d2[31:0]}, "R8 merge upper half");
      drive(1'b1, 6'd1, d4, 8'h81);
      rd(6'd1, {d4[63:56], w[55:32], d2[31:8], d4[7:0]}, "R8 merge bytes 7 and 0");

      // R9 read-modify-write on multi-bit word aborts
      want_evt(1'b1, 6'd0, "R9 rmw multi event");
      drive(1'b1, 6'd0, w, 8'h80);
      want_evt(1'b1, 6'd0, "R9 word unchanged event");
      rd(6'd0, d0 ^ 64'h3, "R9 word unchanged after abort");

      // R9 detect mode aborts on single
      drive(1'b1, 6'd2, d3, 8'hFF);
      set_mode(2'b00);
      drive(1'b1, 6'd2, {32'd0, d3[31:24] ^ 8'h20, 24'd0}, 8'h08);
      set_mode(2'b01);
      want_evt(1'b0, 6'd2, "R9 rmw single event detect");
      drive(1'b1, 6'd2, 64'hAA, 8'h01);
      set_mode(2'b00);
      rd(6'd2, d3 ^ (64'h1 << 29), "R9 detect abort left word");

      // R10 correct mode merges corrected word
      set_mode(2'b10);
      want_evt(1'b0, 6'd2, "R10 rmw single event");
      drive(1'b1, 6'd2, 64'hAA, 8'h01);
      rd(6'd2, {d3[63:8], 8'hAA}, "R10 corrected merge clean");

      // R1 full write repairs a damaged word
      drive(1'b1, 6'd0, d4, 8'hFF);
      rd(6'd0, d4, "R1 full write clears error");

      repeat (4) @(negedge clk);
      check(exp_rsp_d.size() == 0, "R7 all responses seen",
            64'(exp_rsp_d.size()), 64'd0);
      check(exp_evt_d.size() == 0, "R11 all events seen",
            64'(exp_evt_d.size()), 64'd0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule